// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block supervises software by counting ticks from one of two clock-enable inputs and raising an alarm when a selected interval runs out. In supervision mode the alarm is a one-cycle request for a system reset. In interval mode the alarm sets an interrupt flag, so the block can also serve as a periodic tick source for a scheduler. The 16-bit counter is internal and cannot be read or written. Software controls the block only through one 16-bit control word.

Every write to the control word must carry a fixed key in its upper byte. A write with the wrong key is treated as a fault and forces a reset request. A read always returns a different fixed value in the upper byte, so a value read back cannot be written back unchanged. The two bits that configure an external pin (its function and its active edge) are driven straight out of the control word. Software keeps the timer from firing by restarting the counter before the interval ends.

Top module: `wdg_guard`

## Requirements
- R1: A write with bits 15:8 equal to 0x5A is accepted and stores bits 7:0 as the control fields. The fields are: bit 7 hold, bit 6 pin edge select, bit 5 pin function, bit 4 mode (0 supervision, 1 interval), bit 3 counter restart, bit 2 tick source, bits 1:0 interval code.
- R2: `rd_data` bits 15:8 always read 0x69. Bits 7:0 return the stored control fields, with bit 3 always reading 0.
- R3: A write whose bits 15:8 differ from 0x5A raises `rst_req` in the cycle after the write.
- R4: `pin_edge` follows stored bit 6 and `pin_func` follows stored bit 5.
- R5: Interval codes 00, 01, 10 and 11 expire on the 32768th, 8192nd, 512th and 64th counted tick after the counter restarts.
- R6: Tick source 0 counts `tick_fast` and ignores `tick_slow`. Tick source 1 counts `tick_slow` and ignores `tick_fast`.
- R7: On expiry in supervision mode, `rst_req` rises in the next cycle and no flag is set. On expiry in interval mode, `irq_flag` is set in the next cycle and no reset request is made.
- R8: `irq_req` is high exactly when `irq_flag`, `wd_ie` and `glb_ie` are all high. `irq_ack` or `flag_clr` clears the flag.
- R9: An accepted write with bit 3 set restarts the counter from zero.
- R10: While hold is set, the counter does not advance.
- R11: After `rst_n` is released, `rd_data` is 0x6900 (supervision mode, longest interval), `irq_flag` is 0 and `rst_req` is 0.
- R12: `rst_req` lasts one cycle. In that same cycle the control fields, the counter and the flag are already back at their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Write word, key in bits 15:8 |
| rd_data | output | 16 | Control word read value |
| tick_fast | input | 1 | Tick enable for source 0 |
| tick_slow | input | 1 | Tick enable for source 1 |
| wd_ie | input | 1 | Block interrupt enable |
| glb_ie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt serviced strobe, clears flag |
| flag_clr | input | 1 | Software flag clear strobe |
| rst_req | output | 1 | One-cycle system reset request |
| irq_flag | output | 1 | Interval expiry flag |
| irq_req | output | 1 | Gated interrupt request |
| pin_func | output | 1 | Pin function select bit |
| pin_edge | output | 1 | Pin edge select bit |

## Verification
The assertions are checked on every cycle. They cover the following: a wrong key always leads to a reset request, and a restart always zeroes the counter. Hold always freezes the counter. Every expiry leads to the outcome its mode calls for, and each reset request coincides with a clean reset state. Other behaviours can only be shown by the bench's scenarios, because they depend on exact tick counts and on which tick input is selected. These are the precise interval lengths for all four codes, the counting of only the selected tick input, and the resumption of counting after hold.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [7:0] KEY_WR = 8'h5A;
  localparam logic [7:0] KEY_RD = 8'h69;
  localparam logic [7:0] RESTART_MASK = 8'h08;

  typedef struct packed {
    logic       hold;
    logic       edge_sel;
    logic       pin_sel;
    logic       ivl_mode;
    logic       restart;
    logic       src_sel;
    logic [1:0] tap;
  } wdg_ctrl_t;

  function automatic logic key_ok(input logic [15:0] word);
    return word[15:8] == KEY_WR;
  endfunction
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sync_rst,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output wdg_ctrl_t   ctrl_q,
  output logic        key_bad,
  output logic        restart,
  output logic [15:0] rd_data
);
  logic wr_ok;

  assign key_bad = wr_en && !key_ok(wr_data);
  assign wr_ok   = wr_en && key_ok(wr_data);
  assign restart = wr_ok && wr_data[3];
  assign rd_data = {KEY_RD, ctrl_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_q <= '0;
    else if (sync_rst) ctrl_q <= '0;
    else if (wr_ok)    ctrl_q <= wdg_ctrl_t'(wr_data[7:0] & ~RESTART_MASK);
  end
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned EXP_0 = 15,
  parameter int unsigned EXP_1 = 13,
  parameter int unsigned EXP_2 = 9,
  parameter int unsigned EXP_3 = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_rst,
  input  logic             restart,
  input  logic             run,
  input  logic [1:0]       tap,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] tap_last(input logic [1:0] code);
    int unsigned e;
    case (code)
      2'd0:    e = EXP_0;
      2'd1:    e = EXP_1;
      2'd2:    e = EXP_2;
      default: e = EXP_3;
    endcase
    return (ONE << e) - ONE;
  endfunction

  assign expire = run && (cnt_q == tap_last(tap));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (sync_rst || restart)  cnt_q <= '0;
    else if (expire)               cnt_q <= '0;
    else if (run)                  cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned EXP_0 = 15,
  parameter int unsigned EXP_1 = 13,
  parameter int unsigned EXP_2 = 9,
  parameter int unsigned EXP_3 = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        tick_fast,
  input  logic        tick_slow,
  input  logic        wd_ie,
  input  logic        glb_ie,
  input  logic        irq_ack,
  input  logic        flag_clr,
  output logic        rst_req,
  output logic        irq_flag,
  output logic        irq_req,
  output logic        pin_func,
  output logic        pin_edge
);
  wdg_ctrl_t        ctrl_q;
  logic             key_bad, restart, fire, run, tick_w;
  logic             exp_evt, ivl_mode_w, hold_w;
  logic [CNT_W-1:0] cnt_w;

  assign ivl_mode_w = ctrl_q.ivl_mode;
  assign hold_w     = ctrl_q.hold;
  assign tick_w     = ctrl_q.src_sel ? tick_slow : tick_fast;
  assign run        = tick_w && !hold_w;
  assign fire       = key_bad || (exp_evt && !ivl_mode_w);

  wdg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .sync_rst(fire),
    .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .key_bad(key_bad), .restart(restart), .rd_data(rd_data)
  );

  wdg_count #(.CNT_W(CNT_W), .EXP_0(EXP_0), .EXP_1(EXP_1),
              .EXP_2(EXP_2), .EXP_3(EXP_3)) u_count (
    .clk(clk), .rst_n(rst_n), .sync_rst(fire), .restart(restart),
    .run(run), .tap(ctrl_q.tap), .cnt_q(cnt_w), .expire(exp_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      irq_flag <= 1'b0;
    else if (fire)                   irq_flag <= 1'b0;
    else if (exp_evt && ivl_mode_w)  irq_flag <= 1'b1;
    else if (irq_ack || flag_clr)    irq_flag <= 1'b0;
  end

  assign irq_req  = irq_flag && wd_ie && glb_ie;
  assign pin_func = ctrl_q.pin_sel;
  assign pin_edge = ctrl_q.edge_sel;
endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk #(parameter int unsigned CNT_W = 16) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [15:0]      wr_data,
  input logic [15:0]      rd_data,
  input logic             rst_req,
  input logic             irq_flag,
  input logic             irq_ack,
  input logic             flag_clr,
  input logic             exp_evt,
  input logic             ivl_mode,
  input logic             hold,
  input logic [CNT_W-1:0] cnt
);
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[15:8] == 8'h5A && !(exp_evt && !ivl_mode))
      |=> rd_data[7:0] == ($past(wr_data[7:0]) & 8'hF7));

  p_badkey_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[15:8] != 8'h5A) |=> rst_req);

  p_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (rd_data == 16'h6900 && !irq_flag && cnt == '0));

  p_sup_exp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_evt && !ivl_mode) |=> rst_req);

  p_int_exp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_evt && ivl_mode && !(wr_en && wr_data[15:8] != 8'h5A))
      |=> (irq_flag && !rst_req));

  p_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_ack || flag_clr) && !exp_evt) |=> !irq_flag);

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[15:8] == 8'h5A && wr_data[3]) |=> cnt == '0);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !wr_en) |=> $stable(cnt));
endmodule

bind wdg_guard wdg_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .rst_req(rst_req), .irq_flag(irq_flag),
  .irq_ack(irq_ack), .flag_clr(flag_clr), .exp_evt(exp_evt),
  .ivl_mode(ivl_mode_w), .hold(hold_w), .cnt(cnt_w)
);

// File: tb/wdg_guard_tb.sv
`timescale 1ns/1ps
module wdg_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        tick_fast = 1'b0, tick_slow = 1'b0;
  logic        wd_ie = 1'b0, glb_ie = 1'b0, irq_ack = 1'b0, flag_clr = 1'b0;
  logic        rst_req, irq_flag, irq_req, pin_func, pin_edge;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  wdg_guard u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .wd_ie(wd_ie), .glb_ie(glb_ie), .irq_ack(irq_ack), .flag_clr(flag_clr),
    .rst_req(rst_req), .irq_flag(irq_flag), .irq_req(irq_req),
    .pin_func(pin_func), .pin_edge(pin_edge)
  );

  function automatic int ivl_len(input logic [1:0] code);
    case (code)
      2'd0: return 32768;
      2'd1: return 8192;
      2'd2: return 512;
      default: return 64;
    endcase
  endfunction

  function automatic logic [15:0] read_exp(input logic [7:0] low);
    return {8'h69, low & 8'b1111_0111};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] got,
                     input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  // expect the flag to rise exactly on the n-th counted tick
  task automatic expect_flag_at(input int n, input string req);
    repeat (n - 1) step();
    chk(irq_flag == 1'b0, req, irq_flag, 0);
    step();
    chk(irq_flag == 1'b1, req, irq_flag, 1);
  endtask

  task automatic drop_flag();
    tick_fast = 1'b0; tick_slow = 1'b0;
    flag_clr = 1'b1; step(); flag_clr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired got=0 expected=1");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R11 reset state
    chk(rd_data == 16'h6900, "R11 rd", rd_data, 16'h6900);
    chk(rst_req == 1'b0 && irq_flag == 1'b0, "R11 outs", {rst_req, irq_flag}, 0);

    // R5 code 00 in supervision; R7 R12 reset pulse
    tick_fast = 1'b1;
    repeat (32767) step();
    chk(rst_req == 1'b0, "R5 code00 early", rst_req, 0);
    step();
    chk(rst_req == 1'b1, "R7 supervision expiry", rst_req, 1);
    chk(irq_flag == 1'b0, "R7 no flag in supervision", irq_flag, 0);
    chk(rd_data == 16'h6900, "R12 state back to reset", rd_data, 16'h6900);
    tick_fast = 1'b0;
    step();
    chk(rst_req == 1'b0, "R12 single pulse", rst_req, 0);

    // R5 R7 interval codes 01 10 11
    for (int c = 1; c < 4; c++) begin
      wr(16'h5A18 | 16'(c));
      chk(rd_data == read_exp(8'h18 | 8'(c)), "R2 readback", rd_data,
          read_exp(8'h18 | 8'(c)));
      tick_fast = 1'b1;
      expect_flag_at(ivl_len(2'(c)), "R5 interval length");
      chk(rst_req == 1'b0, "R7 no reset in interval", rst_req, 0);
      drop_flag();
    end

    // R6 tick source 1
    wr(16'h5A1F);
    tick_fast = 1'b1;
    repeat (100) step();
    chk(irq_flag == 1'b0, "R6 fast ignored", irq_flag, 0);
    tick_fast = 1'b0; tick_slow = 1'b1;
    expect_flag_at(64, "R6 slow counted");
    drop_flag();

    // R10 hold
    wr(16'h5A9B);
    tick_fast = 1'b1;
    repeat (100) step();
    chk(irq_flag == 1'b0, "R10 hold frozen", irq_flag, 0);
    wr(16'h5A13);
    expect_flag_at(64, "R10 resume after hold");
    drop_flag();

    // R9 restart mid-interval
    wr(16'h5A1B);
    tick_fast = 1'b1;
    repeat (40) step();
    wr(16'h5A1B);
    expect_flag_at(64, "R9 restart");
    tick_fast = 1'b0;

    // R8 gating and clearing
    wd_ie = 1'b1; glb_ie = 1'b0; #1;
    chk(irq_req == 1'b0, "R8 global gate", irq_req, 0);
    glb_ie = 1'b1; #1;
    chk(irq_req == 1'b1, "R8 request", irq_req, 1);
    wd_ie = 1'b0; #1;
    chk(irq_req == 1'b0, "R8 local gate", irq_req, 0);
    wd_ie = 1'b1;
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    chk(irq_flag == 1'b0 && irq_req == 1'b0, "R8 ack clears", irq_flag, 0);

    // R4 pin bits
    wr(16'h5A60);
    chk(pin_func == 1'b1 && pin_edge == 1'b1, "R4 pins", {pin_edge, pin_func}, 2'b11);

    // R3 bad key
    wr(16'hA520);
    chk(rst_req == 1'b1, "R3 bad key", rst_req, 1);
    chk(rd_data == 16'h6900, "R3 reset state", rd_data, 16'h6900);
    step();
    chk(rst_req == 1'b0, "R12 bad key pulse", rst_req, 0);

    // R1 R2 R3 R4 random writes
    for (int i = 0; i < 300; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      if ($urandom % 4 != 0) d[15:8] = 8'h5A;
      wr(d);
      if (d[15:8] == 8'h5A) begin
        chk(rd_data == read_exp(d[7:0]), "R1 accept", rd_data, read_exp(d[7:0]));
        chk(rst_req == 1'b0, "R1 no reset", rst_req, 0);
        chk(pin_func == d[5] && pin_edge == d[6], "R4 pins",
            {pin_edge, pin_func}, {d[6], d[5]});
      end else begin
        chk(rst_req == 1'b1, "R3 reject", rst_req, 1);
        chk(rd_data == 16'h6900, "R3 reject state", rd_data, 16'h6900);
      end
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule